// File: doc/BRIEF.md
# Text-Mode Hardware Cursor Generator

This block decides, one character cell at a time, whether the hardware cursor is lit. It watches the character address and the scanline number produced by the raster timing generator. It raises its cursor output only when three conditions hold: the address equals the programmed cursor position, the scanline lies inside the programmed cursor band, and the selected mode allows the cursor to be seen in the current frame.

A two-bit mode selects one of four behaviours: a steady cursor, a hidden cursor, or a cursor that blinks at one of two rates. A free-running counter advances on each frame tick from the timing generator and sets the blink phase. The output is also gated by display enable, so the cursor never appears in blanking. It is registered, so it lines up with a character address that has been delayed by one clock.

Top module: `crtc_cursor_gen`

## Requirements
- R1: `cursor_en` can be high only when all 14 bits of `mem_addr` equal `cur_addr`; any mismatch in any bit gives low.
- R2: The scanline band is inclusive. `row_addr` equal to `cur_row_first`, equal to `cur_row_last`, or between them qualifies. One row below the first or one row above the last does not.
- R3: When `cur_row_first` is greater than `cur_row_last`, `cursor_en` stays low for every row.
- R4: `cur_mode` encoding: 2'b00 steady (always shown), 2'b01 hidden (never shown), 2'b10 fast blink, 2'b11 slow blink.
- R5: `cursor_en` is low whenever `disp_en` was low in the cycle it qualifies.
- R6: A 5-bit frame counter starts at 0 on reset and increments by one on every cycle where `frame_tick` is high, wrapping from 31 to 0. It runs in every mode.
- R7: In fast blink the cursor is shown while counter bit 3 is 0 (8 frames on, 8 off). In slow blink it is shown while counter bit 4 is 0 (16 on, 16 off).
- R8: `cursor_en` is registered. It reflects the inputs sampled at the previous rising clock edge, and it is 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse per frame |
| disp_en | input | 1 | Display enable from the timing generator |
| mem_addr | input | 14 | Current character memory address |
| row_addr | input | 5 | Scanline within the character row |
| cur_addr | input | 14 | Cursor position |
| cur_mode | input | 2 | Cursor mode (see R4) |
| cur_row_first | input | 5 | First scanline of the cursor band |
| cur_row_last | input | 5 | Last scanline of the cursor band |
| cursor_en | output | 1 | Registered cursor enable |

## Verification
The embedded properties check the blocking conditions on every cycle: an address mismatch, an inverted band, hidden mode or blanking must each force the output low one cycle later. They also check that the frame counter steps only on a tick. Only the directed scenarios can show the positive side. That covers the inclusive band edges, the exact blink phases over more than one full counter wrap at both rates, the counter running on while the cursor is hidden, and the one-clock latency.

// File: rtl/crtc_cursor_pkg.sv
package crtc_cursor_pkg;

   typedef enum logic [1:0] {
      CUR_STEADY = 2'b00,
      CUR_HIDDEN = 2'b01,
      CUR_FAST   = 2'b10,
      CUR_SLOW   = 2'b11
   } cur_mode_e;

endpackage

// File: rtl/crtc_cursor_blink.sv
module crtc_cursor_blink #(
   parameter int FAST_BIT = 3,
   parameter int SLOW_BIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_tick,
   output logic fast_on,
   output logic slow_on
);
   localparam int CNT_W = SLOW_BIT + 1;

   generate
      if (FAST_BIT < 0 || FAST_BIT >= SLOW_BIT) begin : g_bad_bits
         $error("crtc_cursor_blink: FAST_BIT must be below SLOW_BIT");
      end
   endgenerate

   logic [CNT_W-1:0] frame_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         frame_cnt <= '0;
      else if (frame_tick)
         frame_cnt <= frame_cnt + 1'b1;
   end

   assign fast_on = ~frame_cnt[FAST_BIT];
   assign slow_on = ~frame_cnt[SLOW_BIT];

   // R6: counter steps only on a tick
   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick |=> frame_cnt == $past(frame_cnt) + 1'b1);
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> $stable(frame_cnt));
endmodule

// File: rtl/crtc_cursor_match.sv
module crtc_cursor_match #(
   parameter int ADDR_W = 14,
   parameter int ROW_W  = 5
) (
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [ROW_W-1:0]  row_addr,
   input  logic [ROW_W-1:0]  row_first,
   input  logic [ROW_W-1:0]  row_last,
   output logic              hit
);
   generate
      if (ADDR_W < 1 || ROW_W < 1) begin : g_bad_width
         $error("crtc_cursor_match: widths must be positive");
      end
   endgenerate

   logic addr_eq;
   logic row_in;

   always_comb begin
      addr_eq = (mem_addr == cur_addr);
      row_in  = (row_addr >= row_first) && (row_addr <= row_last);
      hit     = addr_eq && row_in;
   end
endmodule

// File: rtl/crtc_cursor_gen.sv
module crtc_cursor_gen
   import crtc_cursor_pkg::*;
#(
   parameter int ADDR_W   = 14,
   parameter int ROW_W    = 5,
   parameter int FAST_BIT = 3,
   parameter int SLOW_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic              disp_en,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [ROW_W-1:0]  row_addr,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [1:0]        cur_mode,
   input  logic [ROW_W-1:0]  cur_row_first,
   input  logic [ROW_W-1:0]  cur_row_last,
   output logic              cursor_en
);
   logic fast_on, slow_on, hit, mode_show;

   crtc_cursor_blink #(.FAST_BIT(FAST_BIT), .SLOW_BIT(SLOW_BIT)) u_blink (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_tick (frame_tick),
      .fast_on    (fast_on),
      .slow_on    (slow_on)
   );

   crtc_cursor_match #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_match (
      .mem_addr  (mem_addr),
      .cur_addr  (cur_addr),
      .row_addr  (row_addr),
      .row_first (cur_row_first),
      .row_last  (cur_row_last),
      .hit       (hit)
   );

   always_comb begin
      unique case (cur_mode_e'(cur_mode))
         CUR_STEADY: mode_show = 1'b1;
         CUR_HIDDEN: mode_show = 1'b0;
         CUR_FAST:   mode_show = fast_on;
         CUR_SLOW:   mode_show = slow_on;
         default:    mode_show = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cursor_en <= 1'b0;
      else
         cursor_en <= disp_en && hit && mode_show;
   end

   // R1: any address difference blocks the cursor
   a_r1_addr_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr != cur_addr) |=> !cursor_en);
   // R3: inverted band never shows
   a_r3_inverted: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_row_first > cur_row_last) |=> !cursor_en);
   // R4: hidden mode never shows
   a_r4_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'b01) |=> !cursor_en);
   // R5: nothing in blanking
   a_r5_blank: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_en |=> !cursor_en);
endmodule

// File: tb/tb_crtc_cursor_gen.sv
module tb_crtc_cursor_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_tick = 1'b0;
   logic        disp_en = 1'b0;
   logic [13:0] mem_addr = '0;
   logic [4:0]  row_addr = '0;
   logic [13:0] cur_addr = '0;
   logic [1:0]  cur_mode = 2'b00;
   logic [4:0]  cur_row_first = '0;
   logic [4:0]  cur_row_last = '0;
   logic        cursor_en;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   crtc_cursor_gen dut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .disp_en(disp_en),
      .mem_addr(mem_addr), .row_addr(row_addr), .cur_addr(cur_addr),
      .cur_mode(cur_mode), .cur_row_first(cur_row_first),
      .cur_row_last(cur_row_last), .cursor_en(cursor_en)
   );

   task automatic expect_now(input logic exp, input string req);
      n_chk++;
      if (cursor_en !== exp) begin
         n_bad++;
         $display("FAIL %s: cursor_en=%b expected %b at %0t", req, cursor_en, exp, $time);
      end
   endtask

   // drive at negedge, check after the next rising edge
   task automatic apply_check(input logic [13:0] a, input logic [4:0] r,
                              input logic de, input logic exp, input string req);
      @(negedge clk);
      mem_addr = a; row_addr = r; disp_en = de;
      @(posedge clk); #1;
      expect_now(exp, req);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; frame_tick = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic tick();
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
   endtask

   task automatic setup(input logic [13:0] pos, input logic [1:0] md,
                        input logic [4:0] f, input logic [4:0] l);
      @(negedge clk);
      cur_addr = pos; cur_mode = md; cur_row_first = f; cur_row_last = l;
   endtask

   task automatic t_reset();
      @(negedge clk); rst_n = 1'b0;
      mem_addr = 14'h0123; cur_addr = 14'h0123; row_addr = 5'd2; disp_en = 1'b1;
      cur_row_first = 5'd0; cur_row_last = 5'd7; cur_mode = 2'b00;
      @(posedge clk); #1; expect_now(1'b0, "R8 reset");
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1; expect_now(1'b1, "R8 first after reset");
   endtask

   task automatic t_addr();
      setup(14'h2A5C, 2'b00, 5'd3, 5'd6);
      apply_check(14'h2A5C, 5'd4, 1'b1, 1'b1, "R1 match");
      apply_check(14'h0A5C, 5'd4, 1'b1, 1'b0, "R1 top bit differs");
      apply_check(14'h2A5D, 5'd4, 1'b1, 1'b0, "R1 low bit differs");
   endtask

   task automatic t_rows();
      setup(14'h0100, 2'b00, 5'd3, 5'd6);
      apply_check(14'h0100, 5'd3, 1'b1, 1'b1, "R2 first row");
      apply_check(14'h0100, 5'd6, 1'b1, 1'b1, "R2 last row");
      apply_check(14'h0100, 5'd2, 1'b1, 1'b0, "R2 below first");
      apply_check(14'h0100, 5'd7, 1'b1, 1'b0, "R2 above last");
      setup(14'h0100, 2'b00, 5'd5, 5'd5);
      apply_check(14'h0100, 5'd5, 1'b1, 1'b1, "R2 single row band");
   endtask

   task automatic t_inverted();
      setup(14'h0100, 2'b00, 5'd6, 5'd3);
      for (int r = 0; r < 32; r++)
         apply_check(14'h0100, 5'(r), 1'b1, 1'b0, "R3 inverted band");
   endtask

   task automatic t_hidden_blank();
      setup(14'h0033, 2'b01, 5'd0, 5'd31);
      apply_check(14'h0033, 5'd0, 1'b1, 1'b0, "R4 hidden mode");
      setup(14'h0033, 2'b00, 5'd0, 5'd31);
      apply_check(14'h0033, 5'd0, 1'b0, 1'b0, "R5 blanking");
      apply_check(14'h0033, 5'd0, 1'b1, 1'b1, "R4 steady mode");
   endtask

   task automatic t_latency();
      setup(14'h0200, 2'b00, 5'd0, 5'd7);
      apply_check(14'h0201, 5'd1, 1'b1, 1'b0, "R8 pre");
      @(negedge clk); mem_addr = 14'h0200;
      #1; expect_now(1'b0, "R8 not before edge");
      @(posedge clk); #1; expect_now(1'b1, "R8 after edge");
   endtask

   // bit: 3 fast, 4 slow
   task automatic t_blink(input logic [1:0] md, input int bit_i, input string req);
      do_reset();
      setup(14'h0777, md, 5'd0, 5'd7);
      for (int n = 0; n < 40; n++) begin
         apply_check(14'h0777, 5'd1, 1'b1, (((n % 32) >> bit_i) & 1) == 0, req);
         tick();
      end
   endtask

   task automatic t_free_run();
      do_reset();
      setup(14'h0777, 2'b01, 5'd0, 5'd7);
      for (int n = 0; n < 8; n++) tick();
      setup(14'h0777, 2'b10, 5'd0, 5'd7);
      apply_check(14'h0777, 5'd1, 1'b1, 1'b0, "R6 counter runs while hidden");
      for (int n = 0; n < 24; n++) tick();
      apply_check(14'h0777, 5'd1, 1'b1, 1'b1, "R6 wrap to zero");
      for (int n = 0; n < 8; n++) tick();
      do_reset();
      apply_check(14'h0777, 5'd1, 1'b1, 1'b1, "R6 reset clears counter");
   endtask

   initial begin
      t_reset();
      t_addr();
      t_rows();
      t_inverted();
      t_hidden_blank();
      t_latency();
      t_blink(2'b10, 3, "R7 fast blink");
      t_blink(2'b11, 4, "R7 slow blink");
      t_free_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #500000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule